// File: doc/BRIEF.md
# Merger Sweep Test Sequencer

This block checks the merge stages of a recursive merge-based sorting network, one merger size at a time. A merger of size M has two sorted inputs, each of half-length L = M/2. With 0/1 data a sorted half of length L can take only L+1 forms, so the sequencer applies all (L+1)^2 pairs of sorted halves and checks that the merged output is sorted. This costs a number of vectors that grows with the square of the half-length, where a full walk of every input pattern grows exponentially.

A harness connects the two half outputs to the merger of the size shown on `merge_size` and returns that merger's output on `merged`. The merger is treated as combinational, and its output is checked in the same cycle the vector is applied. In the full sweep the sequencer starts at the largest size N and halves the size down to 4. A size-2 merger is a single compare-exchange, so it is not tested. A single-size mode tests only one selected merger. At the end the block reports a pass flag, the first failing count pair and its size, the number of vectors applied, and a fault flag. The fault flag is set when that number differs from the closed-form total.

Top module: `merger_sweep_seq`

## Requirements
- R1: After reset `busy`, `done`, `vec_valid`, `pass`, `fail_seen` and `count_fault` are low, and `vec_count` is zero.
- R2: A `start` pulse while idle begins a run on the next clock with both counts at zero. A `start` while `busy` is high has no effect on the running sequence.
- R3: For a count k and a half-length L, a half output holds k ones in bit positions L-1 down to L-k and zeros below them. Bit 0 is the lowest position. All bits at L and above are zero.
- R4: One vector is applied per cycle while `vec_valid` is high. The inner count `kb` (driving `half_b`) runs 0..L and wraps to 0 before the outer count `ka` (driving `half_a`) increments.
- R5: In the full sweep `merge_size` takes the values N, N/2, … 4 in that order. Each size is held for (M/2+1)^2 consecutive vectors.
- R6: If `single_en` is high at start and `single_log` is in 2..log2(N), only the merger of size 2^`single_log` is tested. Any other `single_log` value gives a full sweep.
- R7: A vector passes when bits M-1..0 of `merged` contain no 1 directly below a 0. Bits at M and above are ignored.
- R8: `pass` is high at completion only if every applied vector passed. `done` rises one cycle after the last vector and holds until the next start.
- R9: On the first failing vector, `fail_seen` is set and `ka`, `kb` and the merger size are captured. Later failures in the same run do not change the captured values.
- R10: At completion `vec_count` equals the sum of (M/2+1)^2 over the sizes tested (34 for N=8, 1493 for N=64). `count_fault` is set if the count differs from that sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| single_en | input | 1 | Test one merger size only |
| single_log | input | $clog2(log2(N)+1) | log2 of the size for single mode |
| half_a | output | N/2 | Sorted half driven by the outer count |
| half_b | output | N/2 | Sorted half driven by the inner count |
| merge_size | output | log2(N)+1 | Size M of the merger under test |
| vec_valid | output | 1 | A vector is applied this cycle |
| merged | input | N | Output of the merger under test |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |
| pass | output | 1 | All vectors of the run passed |
| fail_seen | output | 1 | At least one vector failed |
| fail_ka | output | $clog2(N/2+1) | Outer count of the first failure |
| fail_kb | output | $clog2(N/2+1) | Inner count of the first failure |
| fail_size | output | log2(N)+1 | Merger size of the first failure |
| vec_count | output | $clog2(2*(N/2+1)^2) | Vectors applied in this run |
| count_fault | output | 1 | Final count differs from the closed-form total |

## Verification
The hardest case to reach from the ports is a run with several failures spread across different sizes, where the captured record must keep the first failure and ignore the rest. The bench's merger model corrupts one chosen count pair at the largest size and also every vector of the smallest size. It then checks that only the earlier pair is reported. The model also sets every bit above M to one, so that a check which reads past the active merger would fail.

// File: rtl/merger_sweep_seq.sv
module merger_sweep_seq #(
  parameter int N = 64,
  localparam int LOGN = $clog2(N),
  localparam int HW = N / 2,
  localparam int KW = $clog2(HW + 1),
  localparam int LW = $clog2(LOGN + 1),
  localparam int CW = $clog2(2 * (HW + 1) * (HW + 1))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            single_en,
  input  logic [LW-1:0]   single_log,
  output logic [HW-1:0]   half_a,
  output logic [HW-1:0]   half_b,
  output logic [LOGN:0]   merge_size,
  output logic            vec_valid,
  input  logic [N-1:0]    merged,
  output logic            busy,
  output logic            done,
  output logic            pass,
  output logic            fail_seen,
  output logic [KW-1:0]   fail_ka,
  output logic [KW-1:0]   fail_kb,
  output logic [LOGN:0]   fail_size,
  output logic [CW-1:0]   vec_count,
  output logic            count_fault
);

  function automatic int total_vecs();
    int t;
    t = 0;
    for (int s = 2; s <= LOGN; s++) t += ((1 << (s - 1)) + 1) * ((1 << (s - 1)) + 1);
    return t;
  endfunction

  localparam int TOTAL = total_vecs();

  function automatic logic [HW-1:0] therm(input logic [KW-1:0] k, input logic [KW-1:0] len);
    logic [HW:0] t;
    t = ((HW + 1)'(1) << k) - (HW + 1)'(1);
    t = t << (len - k);
    return t[HW-1:0];
  endfunction

  logic            run_q, done_q, single_q, pass_q, fail_q, fault_q;
  logic [LW-1:0]   lg_q;
  logic [KW-1:0]   ka_q, kb_q, fka_q, fkb_q;
  logic [LOGN:0]   fsize_q;
  logic [CW-1:0]   cnt_q, exp_q;

  wire [KW-1:0] half_len = KW'(1 << (int'(lg_q) - 1));
  assign merge_size = (LOGN + 1)'(1) << lg_q;
  assign half_a     = run_q ? therm(ka_q, half_len) : '0;
  assign half_b     = run_q ? therm(kb_q, half_len) : '0;
  assign vec_valid  = run_q;

  wire [N-1:0] mmask = {N{1'b1}} >> (N - int'(merge_size));
  wire [N-1:0] mval  = merged & mmask;
  wire         vec_ok = ~|(mval & ~(mval >> 1) & (mmask >> 1));

  wire          sel_ok   = single_en && int'(single_log) >= 2 && int'(single_log) <= LOGN;
  wire [LW-1:0] start_lg = sel_ok ? single_log : LW'(LOGN);
  logic [CW-1:0] start_exp;
  always_comb begin
    int h;
    h = 1 << (int'(start_lg) - 1);
    start_exp = sel_ok ? CW'((h + 1) * (h + 1)) : CW'(TOTAL);
  end

  wire last_stage = single_q || lg_q == LW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; single_q <= 1'b0; pass_q <= 1'b0;
      fail_q <= 1'b0; fault_q <= 1'b0; lg_q <= LW'(LOGN);
      ka_q <= '0; kb_q <= '0; fka_q <= '0; fkb_q <= '0; fsize_q <= '0;
      cnt_q <= '0; exp_q <= '0;
    end else if (start && !run_q) begin
      run_q <= 1'b1; done_q <= 1'b0; single_q <= sel_ok; pass_q <= 1'b1;
      fail_q <= 1'b0; fault_q <= 1'b0; lg_q <= start_lg;
      ka_q <= '0; kb_q <= '0; fka_q <= '0; fkb_q <= '0; fsize_q <= '0;
      cnt_q <= '0; exp_q <= start_exp;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (!vec_ok) begin
        pass_q <= 1'b0;
        if (!fail_q) begin
          fail_q <= 1'b1; fka_q <= ka_q; fkb_q <= kb_q; fsize_q <= merge_size;
        end
      end
      if (kb_q != half_len) kb_q <= kb_q + 1'b1;
      else begin
        kb_q <= '0;
        if (ka_q != half_len) ka_q <= ka_q + 1'b1;
        else begin
          ka_q <= '0;
          if (last_stage) begin
            run_q <= 1'b0; done_q <= 1'b1;
            fault_q <= (cnt_q + 1'b1) != exp_q;
          end else lg_q <= lg_q - 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign pass = pass_q;
  assign fail_seen = fail_q;
  assign fail_ka = fka_q;
  assign fail_kb = fkb_q;
  assign fail_size = fsize_q;
  assign vec_count = cnt_q;
  assign count_fault = fault_q;

  assert_half_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($countones(half_a) == int'(ka_q) && $countones(half_b) == int'(kb_q)));
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (ka_q <= half_len && kb_q <= half_len));
  assert_size_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(vec_valid)) |-> merge_size <= $past(merge_size));
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(vec_count)));
  assert_fail_clears_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen |-> !pass);
  assert_total_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !count_fault);

endmodule

// File: tb/merger_sweep_seq_test.sv
module merger_sweep_seq_test;
  localparam int N = 8, LOGN = 3, HW = 4, KW = 3, LW = 2, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, single_en = 1'b0;
  logic [LW-1:0] single_log = '0;
  logic [HW-1:0] half_a, half_b;
  logic [LOGN:0] merge_size, fail_size;
  logic vec_valid, busy, done, pass, fail_seen, count_fault;
  logic [N-1:0] merged;
  logic [KW-1:0] fail_ka, fail_kb;
  logic [CW-1:0] vec_count;

  int checks = 0, errors = 0;
  int f_ka = -1, f_kb = -1, f_m = -1, f_all_m = -1;

  always #2 clk = ~clk;

  merger_sweep_seq #(.N(N)) uut (.*);

  always_comb begin
    int ones, m, ka, kb;
    logic [N-1:0] t;
    ones = $countones(half_a) + $countones(half_b);
    ka = $countones(half_a); kb = $countones(half_b);
    m = int'(merge_size);
    t = '0;
    for (int i = 0; i < N; i++) if (i >= m - ones) t[i] = 1'b1;
    if ((ka == f_ka && kb == f_kb && m == f_m) || m == f_all_m) t = (t & ~N'(3)) | N'(1);
    merged = t;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int therm(int k, int len);
    int r = 0;
    for (int i = 0; i < len; i++) if (i >= len - k) r |= 1 << i;
    return r;
  endfunction

  task automatic run(bit sen, int slog, int exp_pass, int mid_start);
    int hi, lo, idx, fseen, fa, fb, fm;
    bit ok;
    ok = sen && slog >= 2 && slog <= LOGN;
    hi = ok ? slog : LOGN;
    lo = ok ? slog : 2;
    idx = 0; fseen = 0; fa = 0; fb = 0; fm = 0;
    @(negedge clk); start = 1'b1; single_en = sen; single_log = LW'(slog);
    for (int lg = hi; lg >= lo; lg--) begin
      int L = 1 << (lg - 1);
      for (int a = 0; a <= L; a++)
        for (int b = 0; b <= L; b++) begin
          @(negedge clk); start = 1'b0;
          chk("R4 vec_valid", vec_valid, 1);
          chk("R5 merge_size", int'(merge_size), 1 << lg);
          chk("R3 half_a", int'(half_a), therm(a, L));
          chk("R4 half_b", int'(half_b), therm(b, L));
          chk("R10 running count", int'(vec_count), idx);
          if (!fseen && ((a == f_ka && b == f_kb && (1 << lg) == f_m) || (1 << lg) == f_all_m)) begin
            fseen = 1; fa = a; fb = b; fm = 1 << lg;
          end
          if (idx == mid_start) start = 1'b1;
          idx++;
        end
    end
    @(negedge clk); start = 1'b0;
    chk("R8 done", done, 1);
    chk("R8 busy low", busy, 0);
    chk("R10 total", int'(vec_count), idx);
    chk("R10 count_fault", count_fault, 0);
    chk("R8 pass", pass, exp_pass);
    chk("R9 fail_seen", fail_seen, fseen);
    if (fseen) begin
      chk("R9 fail_ka", int'(fail_ka), fa);
      chk("R9 fail_kb", int'(fail_kb), fb);
      chk("R9 fail_size", int'(fail_size), fm);
    end
    @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 vec_valid idle", vec_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 vec_valid", vec_valid, 0);
    chk("R1 pass", pass, 0); chk("R1 fail_seen", fail_seen, 0);
    chk("R1 count_fault", count_fault, 0); chk("R1 vec_count", int'(vec_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);
    // R2 full sweep with start pulsed mid-run; R10 total 34
    run(1'b0, 0, 1, 5);
    // R7 R9 single failure at the largest size
    f_ka = 3; f_kb = 1; f_m = 8;
    run(1'b0, 0, 0, -1);
    // R9 first failure kept although all size-4 vectors also fail
    f_ka = 2; f_kb = 0; f_m = 8; f_all_m = 4;
    run(1'b0, 0, 0, -1);
    // R6 single size 4 only
    f_ka = -1; f_kb = -1; f_m = -1; f_all_m = -1;
    run(1'b1, 2, 1, -1);
    // R6 single size 8: broken size-4 merger is not visited
    f_all_m = 4;
    run(1'b1, 3, 1, -1);
    // R6 invalid select falls back to the full sweep
    run(1'b1, 0, 0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule